// File: doc/BRIEF.md
# Eight-Bit Compare-Match Timer

This block is an 8-bit up-counter with two compare registers, named A and B, and one timer output pin. The count source comes from a three-bit clock-select code. The code can stop the counter, pick one of three taps of a free-running prescaler on the system clock, or count an external clock input on its rising edge, its falling edge or both edges. The external input passes through a synchronizer, and its edges are detected in the system-clock domain. The counter therefore advances at most once per system clock.

A status register holds three event flags: compare-match B, compare-match A and counter overflow. Each flag drives an interrupt request output. Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit never sets it. The same register holds two two-bit output-action fields, one per compare. Each field decides what a match does to the timer output: nothing, drive low, drive high, or toggle.

All registers are reached over a simple synchronous bus. A write happens on the clock edge where both the select and the write strobe are high. Read data is combinational from the address.

Top module: `cmt8_timer`

## Requirements
- R1: After reset, the registers read as follows. Address 0 (control, clock select in bits 2:0, upper bits read 0) reads 0x00. Address 1 (status) reads 0x10. Addresses 2 (compare A) and 3 (compare B) read 0xFF. Address 4 (counter) reads 0x00. The timer output and all interrupt outputs are 0.
- R2: Clock-select codes 0 and 4 stop the counter. It holds its value even while the external input toggles.
- R3: Codes 1, 2 and 3 advance the counter by one every 2^DIV_LOG1, 2^DIV_LOG2 and 2^DIV_LOG3 system clocks respectively.
- R4: Code 5 counts rising edges of the external input, code 6 counts falling edges, and code 7 counts both. Each counted edge adds exactly one.
- R5: Status bit 5 (overflow) sets when the counter wraps from 0xFF to 0x00. It reads 1 in the same cycle in which the counter first reads 0x00.
- R6: The counter can arrive at the value of compare A either by counting or by a bus write. In the cycle after it arrives, status bit 6 sets. Status bit 7 does the same for compare B.
- R7: Writing 0 to any of status bits 7..5 clears that flag. Writing 1 to them has no effect. Bit 4 always reads 1. Bits 3:2 (compare B action) and 1:0 (compare A action) are plain read/write bits.
- R8: A flag whose set event and clearing write fall on the same clock edge ends up set.
- R9: An action code sets the timer output on a match as follows: 00 leaves it unchanged, 01 drives it 0, 10 drives it 1, and 11 inverts it. The output changes on the same edge as the flag.
- R10: When A and B match on the same edge and the B action code is not 00, the B action is applied. Otherwise the A action is applied.
- R11: The interrupt outputs for compare A, compare B and overflow equal status bits 6, 7 and 5 respectively.
- R12: Values written to the counter, compare and control registers read back unchanged. The control register keeps only bits 2:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data |
| ext_clk | input | 1 | External count clock (asynchronous) |
| tmr_out | output | 1 | Timer output driven by compare actions |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The bench builds the timer with prescaler taps of 1, 2 and 4 bits. The three internal rates then become periods of 2, 4 and 16 clocks, so the bench can measure each period exactly between consecutive counter steps. The counter width stays at 8, so a wrap past 0xFF and every compare value can be reached with a few external edges from a written start value. This small setup allows sweeps over all four action codes for each compare, and over all sixteen action pairs for simultaneous matches.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  typedef enum logic [2:0] {
    SRC_OFF_LO   = 3'd0,
    SRC_DIV_A    = 3'd1,
    SRC_DIV_B    = 3'd2,
    SRC_DIV_C    = 3'd3,
    SRC_OFF_HI   = 3'd4,
    SRC_EXT_RISE = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_BOTH = 3'd7
  } src_sel_e;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_STAT  = 3'd1;
  localparam logic [2:0] ADR_CMPA  = 3'd2;
  localparam logic [2:0] ADR_CMPB  = 3'd3;
  localparam logic [2:0] ADR_COUNT = 3'd4;

  // status bit positions
  localparam int ST_FB  = 7;
  localparam int ST_FA  = 6;
  localparam int ST_OVF = 5;
  localparam int ST_ONE = 4;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // choose the count pulse for a given source code
  function automatic logic pick_tick(input src_sel_e sel, input logic [2:0] taps,
                                     input logic rise, input logic fall);
    case (sel)
      SRC_DIV_A:    return taps[0];
      SRC_DIV_B:    return taps[1];
      SRC_DIV_C:    return taps[2];
      SRC_EXT_RISE: return rise;
      SRC_EXT_FALL: return fall;
      SRC_EXT_BOTH: return rise | fall;
      default:      return 1'b0;
    endcase
  endfunction

  // effect of one action code on the output level
  function automatic logic apply_action(input logic [1:0] code, input logic cur);
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  // B wins when both match and B carries a nonzero action
  function automatic logic next_out(input logic hit_a, input logic hit_b,
                                    input logic [1:0] act_a, input logic [1:0] act_b,
                                    input logic cur);
    if (hit_b && act_b != 2'b00) return apply_action(act_b, cur);
    if (hit_a)                   return apply_action(act_a, cur);
    return cur;
  endfunction

  // sticky flag: hardware set beats software clear
  function automatic logic flag_next(input logic cur, input logic set_ev, input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int LOG_A = 3,
  parameter int LOG_B = 6,
  parameter int LOG_C = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tap_pulse
);
  import cmt_pkg::*;

  localparam int PW = max3(LOG_A, LOG_B, LOG_C);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tap
    localparam int TL = (g == 0) ? LOG_A : ((g == 1) ? LOG_B : LOG_C);
    assign tap_pulse[g] = &div_q[TL-1:0];
  end

endmodule

// File: rtl/cmt_extedge.sv
module cmt_extedge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain_q;
  logic            now_lvl;
  logic            old_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], ext_in};
  end

  assign now_lvl = chain_q[STAGES-1];
  assign old_lvl = chain_q[STAGES];
  assign rise    = now_lvl & ~old_lvl;
  assign fall    = ~now_lvl & old_lvl;

endmodule

// File: rtl/cmt_core.sv
module cmt_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [1:0]       act_a,
  input  logic [1:0]       act_b,
  input  logic             st_wr,
  input  logic [2:0]       st_keep,   // {B, A, OVF} bits as written
  output logic [CNT_W-1:0] count,
  output logic             flag_a,
  output logic             flag_b,
  output logic             flag_ovf,
  output logic             tmo,
  output logic             evt_a,
  output logic             evt_b,
  output logic             evt_ovf
);
  import cmt_pkg::*;

  logic upd_q;
  logic clr_a, clr_b, clr_ovf;

  assign evt_ovf = tick & ~cnt_wr & (count == {CNT_W{1'b1}});
  assign evt_a   = upd_q & (count == cmp_a);
  assign evt_b   = upd_q & (count == cmp_b);

  assign clr_b   = st_wr & ~st_keep[2];
  assign clr_a   = st_wr & ~st_keep[1];
  assign clr_ovf = st_wr & ~st_keep[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= tick | cnt_wr;
      if (cnt_wr)    count <= cnt_wdata;
      else if (tick) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      flag_ovf <= 1'b0;
      tmo      <= 1'b0;
    end else begin
      flag_a   <= flag_next(flag_a, evt_a, clr_a);
      flag_b   <= flag_next(flag_b, evt_b, clr_b);
      flag_ovf <= flag_next(flag_ovf, evt_ovf, clr_ovf);
      tmo      <= next_out(evt_a, evt_b, act_a, act_b, tmo);
    end
  end

endmodule

// File: rtl/cmt8_timer.sv
module cmt8_timer #(
  parameter int CNT_W    = 8,
  parameter int DIV_LOG1 = 3,
  parameter int DIV_LOG2 = 6,
  parameter int DIV_LOG3 = 10,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_clk,
  output logic             tmr_out,
  output logic             irq_cmpa,
  output logic             irq_cmpb,
  output logic             irq_ovf
);
  import cmt_pkg::*;

  localparam logic [CNT_W-1:0] CMP_INIT = {CNT_W{1'b1}};

  logic             wr_en;
  logic             st_wr, cnt_wr;
  src_sel_e         cks;
  logic [CNT_W-1:0] cmp_a, cmp_b, count;
  logic [1:0]       act_a, act_b;
  logic [2:0]       taps;
  logic             rise, fall, tick;
  logic             flag_a, flag_b, flag_ovf, tmo;
  logic             evt_a, evt_b, evt_ovf;
  logic [7:0]       status;

  assign wr_en  = bus_sel & bus_wr;
  assign st_wr  = wr_en & (bus_addr == ADR_STAT);
  assign cnt_wr = wr_en & (bus_addr == ADR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cks   <= SRC_OFF_LO;
      cmp_a <= CMP_INIT;
      cmp_b <= CMP_INIT;
      act_a <= 2'b00;
      act_b <= 2'b00;
    end else if (wr_en) begin
      case (bus_addr)
        ADR_CTRL: cks   <= src_sel_e'(bus_wdata[2:0]);
        ADR_CMPA: cmp_a <= bus_wdata;
        ADR_CMPB: cmp_b <= bus_wdata;
        ADR_STAT: begin
          act_b <= bus_wdata[3:2];
          act_a <= bus_wdata[1:0];
        end
        default: ;
      endcase
    end
  end

  cmt_prescaler #(.LOG_A(DIV_LOG1), .LOG_B(DIV_LOG2), .LOG_C(DIV_LOG3)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_pulse (taps)
  );

  cmt_extedge #(.STAGES(SYNC_N)) u_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_in (ext_clk),
    .rise   (rise),
    .fall   (fall)
  );

  assign tick = pick_tick(cks, taps, rise, fall);

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (bus_wdata),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .act_a     (act_a),
    .act_b     (act_b),
    .st_wr     (st_wr),
    .st_keep   ({bus_wdata[ST_FB], bus_wdata[ST_FA], bus_wdata[ST_OVF]}),
    .count     (count),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .flag_ovf  (flag_ovf),
    .tmo       (tmo),
    .evt_a     (evt_a),
    .evt_b     (evt_b),
    .evt_ovf   (evt_ovf)
  );

  assign status = {flag_b, flag_a, flag_ovf, 1'b1, act_b, act_a};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL:  bus_rdata = CNT_W'(cks);
      ADR_STAT:  bus_rdata = CNT_W'(status);
      ADR_CMPA:  bus_rdata = cmp_a;
      ADR_CMPB:  bus_rdata = cmp_b;
      ADR_COUNT: bus_rdata = count;
      default:   bus_rdata = '0;
    endcase
  end

  assign tmr_out  = tmo;
  assign irq_cmpa = flag_a;
  assign irq_cmpb = flag_b;
  assign irq_ovf  = flag_ovf;

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cks,
  input logic             tick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] count,
  input logic             evt_a,
  input logic             evt_b,
  input logic             evt_ovf,
  input logic             st_wr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [2:0]       bus_addr,
  input logic [CNT_W-1:0] bus_rdata,
  input logic [1:0]       act_a,
  input logic [1:0]       act_b,
  input logic             tmr_out,
  input logic             irq_cmpa,
  input logic             irq_cmpb,
  input logic             irq_ovf
);

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cks == 3'd0 || cks == 3'd4) && !cnt_wr) |=> (count == $past(count)));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> (irq_ovf && count == '0));

  // R6
  cmpa_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_a |=> irq_cmpa);

  // R6
  cmpb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_b |=> irq_cmpb);

  // R7
  no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_ovf && !irq_ovf) |=> !irq_ovf);

  // R7
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1) |-> bus_rdata[4]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a && st_wr && !bus_wdata[6]) |=> irq_cmpa);

  // R9
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a && !evt_b && act_a == 2'b11) |=> (tmr_out != $past(tmr_out)));

  // R10
  b_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a && evt_b && act_b == 2'b01) |=> !tmr_out);

  // R11
  irq_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1) |-> (bus_rdata[7] == irq_cmpb && bus_rdata[6] == irq_cmpa));

endmodule

bind cmt8_timer cmt_checker #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cks       (cks),
  .tick      (tick),
  .cnt_wr    (cnt_wr),
  .count     (count),
  .evt_a     (evt_a),
  .evt_b     (evt_b),
  .evt_ovf   (evt_ovf),
  .st_wr     (st_wr),
  .bus_wdata (bus_wdata),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .act_a     (act_a),
  .act_b     (act_b),
  .tmr_out   (tmr_out),
  .irq_cmpa  (irq_cmpa),
  .irq_cmpb  (irq_cmpb),
  .irq_ovf   (irq_ovf)
);

// File: tb/test_cmt8_timer.sv
`timescale 1ns/1ps
module test_cmt8_timer;

  localparam int L1 = 1;
  localparam int L2 = 2;
  localparam int L3 = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic       tmr_out, irq_cmpa, irq_cmpb, irq_ovf;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic exp_out = 1'b0;

  always #4 clk = ~clk;

  cmt8_timer #(.CNT_W(8), .DIV_LOG1(L1), .DIV_LOG2(L2), .DIV_LOG3(L3)) i_cmt8_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .tmr_out(tmr_out), .irq_cmpa(irq_cmpa),
    .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic edge_ext();
    ext_clk = ~ext_clk;
    repeat (5) @(negedge clk);
  endtask

  // action code model
  function automatic logic act_model(input logic [1:0] c, input logic cur);
    if (c == 2'b01) return 1'b0;
    if (c == 2'b10) return 1'b1;
    if (c == 2'b11) return !cur;
    return cur;
  endfunction

  task automatic measure(output int gap);
    logic [7:0] c0, c1;
    int guard;
    rd(3'd4, c0);
    guard = 0;
    do begin @(negedge clk); rd(3'd4, c1); guard++; end while (c1 == c0 && guard < 200);
    c0 = c1;
    gap = 0;
    do begin @(negedge clk); rd(3'd4, c1); gap++; end while (c1 == c0 && gap < 200);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int gap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(3'd1, d); chk("R1 status", d, 8'h10);
    rd(3'd2, d); chk("R1 cmpA", d, 8'hFF);
    rd(3'd3, d); chk("R1 cmpB", d, 8'hFF);
    rd(3'd4, d); chk("R1 count", d, 8'h00);
    chk("R1 outputs", {tmr_out, irq_cmpa, irq_cmpb, irq_ovf}, 4'b0000);

    // R12 readback
    wr(3'd2, 8'h5A); rd(3'd2, d); chk("R12 cmpA", d, 8'h5A);
    wr(3'd3, 8'hA5); rd(3'd3, d); chk("R12 cmpB", d, 8'hA5);
    wr(3'd4, 8'h3C); rd(3'd4, d); chk("R12 count", d, 8'h3C);
    wr(3'd0, 8'hF8); rd(3'd0, d); chk("R12 ctrl", d, 8'h00);

    // R2 stop codes ignore external edges
    for (int code = 0; code < 8; code += 4) begin
      wr(3'd0, 8'(code));
      wr(3'd4, 8'h21);
      for (int k = 0; k < 6; k++) edge_ext();
      repeat (20) @(negedge clk);
      rd(3'd4, d); chk($sformatf("R2 code %0d", code), d, 8'h21);
    end

    // R3 prescaler periods
    for (int code = 1; code <= 3; code++) begin
      wr(3'd0, 8'(code));
      for (int rep = 0; rep < 3; rep++) begin
        measure(gap);
        chk($sformatf("R3 code %0d period", code), gap,
            1 << ((code == 1) ? L1 : (code == 2) ? L2 : L3));
      end
    end

    // R4 external edge modes
    wr(3'd0, 8'h00);
    ext_clk = 1'b0;
    repeat (6) @(negedge clk);
    for (int code = 5; code <= 7; code++) begin
      wr(3'd0, 8'(code));
      wr(3'd4, 8'h00);
      for (int k = 0; k < 12; k++) edge_ext();
      rd(3'd4, d);
      chk($sformatf("R4 code %0d", code), d, (code == 7) ? 8'd12 : 8'd6);
    end

    // R6 R9 compare A action sweep; R11 irq view
    wr(3'd2, 8'h10); wr(3'd3, 8'h20);
    for (int c = 0; c < 4; c++) begin
      wr(3'd1, 8'(c));
      wr(3'd4, 8'h0F);
      edge_ext();
      exp_out = act_model(2'(c), exp_out);
      rd(3'd1, d); chk("R6 flag A status", d, 8'h50 | 8'(c));
      chk("R9 output after A", tmr_out, exp_out);
      chk("R11 irq A", {irq_cmpb, irq_cmpa, irq_ovf}, 3'b010);
    end

    // R6 R9 compare B action sweep
    for (int c = 0; c < 4; c++) begin
      wr(3'd1, 8'(c << 2));
      wr(3'd4, 8'h1F);
      edge_ext();
      exp_out = act_model(2'(c), exp_out);
      rd(3'd1, d); chk("R6 flag B status", d, 8'h90 | 8'(c << 2));
      chk("R9 output after B", tmr_out, exp_out);
      chk("R11 irq B", {irq_cmpb, irq_cmpa, irq_ovf}, 3'b100);
    end

    // R10 simultaneous matches, all action pairs
    wr(3'd2, 8'h30); wr(3'd3, 8'h30);
    for (int cb = 0; cb < 4; cb++) begin
      for (int ca = 0; ca < 4; ca++) begin
        wr(3'd1, 8'((cb << 2) | ca));
        wr(3'd4, 8'h2F);
        edge_ext();
        exp_out = (cb != 0) ? act_model(2'(cb), exp_out) : act_model(2'(ca), exp_out);
        chk($sformatf("R10 pair b%0d a%0d", cb, ca), tmr_out, exp_out);
        rd(3'd1, d); chk("R10 both flags", d, 8'hD0 | 8'((cb << 2) | ca));
      end
    end

    // R5 overflow
    wr(3'd1, 8'h00);
    wr(3'd4, 8'hFE);
    edge_ext();
    rd(3'd1, d); chk("R5 no flag at FF", d, 8'h10);
    edge_ext();
    rd(3'd4, d); chk("R5 wrapped count", d, 8'h00);
    rd(3'd1, d); chk("R5 overflow flag", d, 8'h30);
    chk("R11 irq ovf", irq_ovf, 1'b1);

    // R7 write-one keeps, write-zero clears, ones never set
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R7 write ones", d, 8'h3F);
    wr(3'd1, 8'hDF); rd(3'd1, d); chk("R7 clear ovf", d, 8'h1F);
    wr(3'd1, 8'hE0); rd(3'd1, d); chk("R7 no set by one", d, 8'h10);
    chk("R7 irqs low", {irq_cmpb, irq_cmpa, irq_ovf}, 3'b000);

    // R8 set and clear on the same edge
    wr(3'd2, 8'h40); wr(3'd3, 8'hFF);
    wr(3'd4, 8'h3F);
    ext_clk = ~ext_clk;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h00;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(3'd1, d); chk("R8 set wins", d, 8'h50);
    wr(3'd1, 8'h00); rd(3'd1, d); chk("R7 later clear", d, 8'h10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule